// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox

This block connects two processors, side A and side B, that share one clock. Each side has its own small register port with four registers: a sync register, a control/status register, a send register and a receive register. There is one word queue per direction. Words that a side writes to its send register go into its outgoing queue. The other side pops them, in order, through its receive register. Each side has status flags, a sticky error flag, a transfer enable, a flush command and two level interrupts for its queues.

Next to the queues is an 8-bit sync channel. Each side drives one byte that the other side can read at once. Two doorbell bits raise a one-cycle interrupt pulse toward side A or side B, but only if the target side has turned on its sync interrupt.

Top module: `ipc_mailbox`

## Requirements
- R1: A write to sync bits 15:8 sets the local sync byte. The other side reads that byte on its sync bits 7:0, and the local side reads it back on bits 15:8. Sync bit 31 reads back the local sync interrupt enable. All other sync bits read 0.
- R2: Sync writes honour the byte enables. Lane 1 (bits 15:8) updates the sync byte. Lane 3 updates the enable (bit 31) and the doorbells (bits 29 and 30). A write with lane 1 disabled leaves the sync byte unchanged.
- R3: A sync write with lane 3 and bit 30 set targets side A. A sync write with lane 3 and bit 29 set targets side B. Either side can write either bit. The target's sync interrupt is high for exactly the one cycle after the write edge, and only if the target's bit 31 was set before that write.
- R4: Words are delivered first in, first out. Each queue holds DEPTH words (16 by default). Control bits: 0 = send queue empty, 1 = send queue full, 8 = receive queue empty, 9 = receive queue full. The receive register returns the head word in the same cycle as the read, and that read pops the word.
- R5: A send write while the send queue is full drops the word and sets control bit 14.
- R6: A receive read while the receive queue is empty returns the last word popped on that side (0 after reset) and sets control bit 14.
- R7: Writing 1 to control bit 14, with lane 1 enabled, clears the error flag.
- R8: Writing 1 to control bit 3, with lane 0 enabled, empties the local send queue. Bit 3 always reads 0.
- R9: While control bit 15 is 0, send writes do not push, receive reads do not pop, and neither one sets the error flag. A read in this state returns the last popped word.
- R10: The send interrupt equals control bit 2 AND send-empty. The receive interrupt equals control bit 10 AND NOT receive-empty. Both are levels.
- R11: After reset, both queues are empty, all enables and errors are 0, both control registers read 0x00000101, and every interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | Side A access strobe |
| a_write | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 2 | Side A register: 0 sync, 1 control, 2 send, 3 receive |
| a_be | input | 4 | Side A byte enables |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (combinational) |
| a_irq_sync | output | 1 | Side A doorbell pulse |
| a_irq_send | output | 1 | Side A send-empty interrupt |
| a_irq_recv | output | 1 | Side A receive-not-empty interrupt |
| b_valid | input | 1 | Side B access strobe |
| b_write | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 2 | Side B register select |
| b_be | input | 4 | Side B byte enables |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (combinational) |
| b_irq_sync | output | 1 | Side B doorbell pulse |
| b_irq_send | output | 1 | Side B send-empty interrupt |
| b_irq_recv | output | 1 | Side B receive-not-empty interrupt |

## Verification
Read data is due in the same cycle as the access. Every state change caused by an access appears from the next clock edge: status bits, error flag, queue contents and the two level interrupts. The doorbell pulse is high in exactly the cycle after the edge that takes the sync write. The bench drives each access just after a falling edge and samples all outputs 1 ns later. At that point it compares them with a behavioural model that holds the pre-edge state, and only then does it advance the model, so each result is checked in the cycle it is due.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned WORD_W = 32;

    localparam int CTL_SEMPTY = 0;
    localparam int CTL_SFULL  = 1;
    localparam int CTL_SIE    = 2;
    localparam int CTL_SFLUSH = 3;
    localparam int CTL_REMPTY = 8;
    localparam int CTL_RFULL  = 9;
    localparam int CTL_RIE    = 10;
    localparam int CTL_ERR    = 14;
    localparam int CTL_EN     = 15;

    localparam int SYN_BYTE_LSB = 8;
    localparam int SYN_RING_B   = 29;
    localparam int SYN_RING_A   = 30;
    localparam int SYN_IEN      = 31;

    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;

    typedef enum logic [1:0] {
        REG_SYNC = 2'd0,
        REG_CTRL = 2'd1,
        REG_SEND = 2'd2,
        REG_RECV = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        reg_sel_e          sel;
        logic [3:0]        be;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic empty;
        logic full;
    } fifo_stat_t;

    typedef struct packed {
        logic en;
        logic err;
        logic rie;
        logic sie;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] pack_ctrl(ctrl_t c, fifo_stat_t s, fifo_stat_t r);
        logic [WORD_W-1:0] v;
        v = '0;
        v[CTL_SEMPTY] = s.empty;
        v[CTL_SFULL]  = s.full;
        v[CTL_SIE]    = c.sie;
        v[CTL_REMPTY] = r.empty;
        v[CTL_RFULL]  = r.full;
        v[CTL_RIE]    = c.rie;
        v[CTL_ERR]    = c.err;
        v[CTL_EN]     = c.en;
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] pack_sync(logic ien, logic [7:0] own, logic [7:0] peer);
        logic [WORD_W-1:0] v;
        v = '0;
        v[SYN_IEN] = ien;
        v[SYN_BYTE_LSB +: 8] = own;
        v[7:0] = peer;
        return v;
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == $past(count)));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  fifo_stat_t        snd,
    input  fifo_stat_t        rcv,
    input  logic [WORD_W-1:0] rcv_head,
    input  logic [7:0]        peer_byte,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              pop,
    output logic              flush,
    output logic [WORD_W-1:0] rdata,
    output logic [7:0]        own_byte,
    output logic              sync_ien,
    output logic [1:0]        ring,
    output logic              irq_send,
    output logic              irq_recv
);
    ctrl_t             ctl_q;
    logic [WORD_W-1:0] last_q;
    logic [7:0]        own_q;
    logic              ien_q;
    logic              wr, rd, wr_sync, wr_ctrl, err_ev;
    logic              unused_lane2;

    assign unused_lane2 = req.be[2];

    assign wr      = req.valid && req.write;
    assign rd      = req.valid && !req.write;
    assign wr_sync = wr && (req.sel == REG_SYNC);
    assign wr_ctrl = wr && (req.sel == REG_CTRL);

    assign push      = wr && (req.sel == REG_SEND) && ctl_q.en;
    assign push_data = req.wdata;
    assign pop       = rd && (req.sel == REG_RECV) && ctl_q.en;
    assign flush     = wr_ctrl && req.be[0] && req.wdata[CTL_SFLUSH];
    assign err_ev    = (push && snd.full) || (pop && rcv.empty);

    assign ring[SIDE_A] = wr_sync && req.be[3] && req.wdata[SYN_RING_A];
    assign ring[SIDE_B] = wr_sync && req.be[3] && req.wdata[SYN_RING_B];

    assign own_byte = own_q;
    assign sync_ien = ien_q;
    assign irq_send = ctl_q.sie && snd.empty;
    assign irq_recv = ctl_q.rie && !rcv.empty;

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (req.sel)
                REG_SYNC: rdata = pack_sync(ien_q, own_q, peer_byte);
                REG_CTRL: rdata = pack_ctrl(ctl_q, snd, rcv);
                REG_RECV: rdata = (ctl_q.en && !rcv.empty) ? rcv_head : last_q;
                default:  rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            last_q <= '0;
            own_q  <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (wr_ctrl && req.be[0]) ctl_q.sie <= req.wdata[CTL_SIE];
            if (wr_ctrl && req.be[1]) begin
                ctl_q.rie <= req.wdata[CTL_RIE];
                ctl_q.en  <= req.wdata[CTL_EN];
            end
            if (err_ev)
                ctl_q.err <= 1'b1;
            else if (wr_ctrl && req.be[1] && req.wdata[CTL_ERR])
                ctl_q.err <= 1'b0;
            if (pop && !rcv.empty) last_q <= rcv_head;
            if (wr_sync && req.be[1]) own_q <= req.wdata[SYN_BYTE_LSB +: 8];
            if (wr_sync && req.be[3]) ien_q <= req.wdata[SYN_IEN];
        end
    end

    // R5
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        err_ev |=> ctl_q.err);

    // R7
    err_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && req.be[1] && req.wdata[CTL_ERR]) |=> !ctl_q.err);

    // R6
    last_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && rcv.empty) |=> $stable(last_q));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        a_valid,
    input  logic        a_write,
    input  logic [1:0]  a_addr,
    input  logic [3:0]  a_be,
    input  logic [31:0] a_wdata,
    output logic [31:0] a_rdata,
    output logic        a_irq_sync,
    output logic        a_irq_send,
    output logic        a_irq_recv,
    input  logic        b_valid,
    input  logic        b_write,
    input  logic [1:0]  b_addr,
    input  logic [3:0]  b_be,
    input  logic [31:0] b_wdata,
    output logic [31:0] b_rdata,
    output logic        b_irq_sync,
    output logic        b_irq_send,
    output logic        b_irq_recv
);
    localparam int unsigned SIDES = 2;

    bus_req_t          req       [SIDES];
    fifo_stat_t        stat      [SIDES];
    logic [WORD_W-1:0] push_data [SIDES];
    logic [WORD_W-1:0] head      [SIDES];
    logic [WORD_W-1:0] rdata     [SIDES];
    logic [7:0]        own_byte  [SIDES];
    logic [1:0]        ring      [SIDES];
    logic [SIDES-1:0]  push, pop, flush, empty, full, ien;
    logic [SIDES-1:0]  irq_send, irq_recv, irq_sync_q;

    assign req[SIDE_A] = '{valid: a_valid, write: a_write, sel: reg_sel_e'(a_addr),
                           be: a_be, wdata: a_wdata};
    assign req[SIDE_B] = '{valid: b_valid, write: b_write, sel: reg_sel_e'(b_addr),
                           be: b_be, wdata: b_wdata};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        assign stat[s] = '{empty: empty[s], full: full[s]};

        mbx_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (push[s]),
            .wdata (push_data[s]),
            .pop   (pop[SIDES-1-s]),
            .flush (flush[s]),
            .head  (head[s]),
            .empty (empty[s]),
            .full  (full[s])
        );

        mbx_port u_port (
            .clk       (clk),
            .rst       (rst),
            .req       (req[s]),
            .snd       (stat[s]),
            .rcv       (stat[SIDES-1-s]),
            .rcv_head  (head[SIDES-1-s]),
            .peer_byte (own_byte[SIDES-1-s]),
            .push      (push[s]),
            .push_data (push_data[s]),
            .pop       (pop[s]),
            .flush     (flush[s]),
            .rdata     (rdata[s]),
            .own_byte  (own_byte[s]),
            .sync_ien  (ien[s]),
            .ring      (ring[s]),
            .irq_send  (irq_send[s]),
            .irq_recv  (irq_recv[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_sync_q <= '0;
        end else begin
            for (int t = 0; t < SIDES; t++)
                irq_sync_q[t] <= ien[t] && (ring[SIDE_A][t] || ring[SIDE_B][t]);
        end
    end

    // R3
    sync_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_sync_q[SIDE_A] |-> $past(ien[SIDE_A]));

    assign a_rdata    = rdata[SIDE_A];
    assign b_rdata    = rdata[SIDE_B];
    assign a_irq_sync = irq_sync_q[SIDE_A];
    assign b_irq_sync = irq_sync_q[SIDE_B];
    assign a_irq_send = irq_send[SIDE_A];
    assign b_irq_send = irq_send[SIDE_B];
    assign a_irq_recv = irq_recv[SIDE_A];
    assign b_irq_recv = irq_recv[SIDE_B];

endmodule

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        v [2];
    logic        w [2];
    logic [1:0]  ad [2];
    logic [3:0]  be [2];
    logic [31:0] wd [2];
    logic [31:0] rdata [2];
    logic        isync [2], isend [2], irecv [2];

    ipc_mailbox #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .a_valid(v[0]), .a_write(w[0]), .a_addr(ad[0]), .a_be(be[0]), .a_wdata(wd[0]),
        .a_rdata(rdata[0]), .a_irq_sync(isync[0]), .a_irq_send(isend[0]), .a_irq_recv(irecv[0]),
        .b_valid(v[1]), .b_write(w[1]), .b_addr(ad[1]), .b_be(be[1]), .b_wdata(wd[1]),
        .b_rdata(rdata[1]), .b_irq_sync(isync[1]), .b_irq_send(isend[1]), .b_irq_recv(irecv[1])
    );

    typedef logic [31:0] wq_t [$];
    wq_t         q [2];
    logic [31:0] m_last [2];
    logic [7:0]  m_own [2];
    logic        m_err [2], m_en [2], m_sie [2], m_rie [2], m_ien [2], m_isync [2];

    int n_chk = 0;
    int n_bad = 0;

    bit          want_on = 0;
    int          want_kind, want_s;
    logic [31:0] want_val;
    string       want_tag;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata(int s);
        int r = 1 - s;
        logic [31:0] x = '0;
        if (v[s] && !w[s]) begin
            case (ad[s])
                2'd0: x = {m_ien[s], 15'b0, m_own[s], m_own[r]};
                2'd1: begin
                    x[0]  = (q[s].size() == 0);
                    x[1]  = (q[s].size() == DEPTH);
                    x[2]  = m_sie[s];
                    x[8]  = (q[r].size() == 0);
                    x[9]  = (q[r].size() == DEPTH);
                    x[10] = m_rie[s];
                    x[14] = m_err[s];
                    x[15] = m_en[s];
                end
                2'd3: x = (m_en[s] && q[r].size() > 0) ? q[r][0] : m_last[s];
                default: x = '0;
            endcase
        end
        return x;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            q[s].delete();
            m_last[s] = '0; m_own[s] = '0; m_err[s] = 0; m_en[s] = 0;
            m_sie[s] = 0; m_rie[s] = 0; m_ien[s] = 0; m_isync[s] = 0;
        end
    endtask

    task automatic model_step();
        bit pushq [2], popq [2], flq [2], ev [2], clr [2];
        bit ring [2][2];
        logic nsie [2], nrie [2], nen [2], nien [2];
        logic [7:0] nown [2];
        for (int s = 0; s < 2; s++) begin
            int r = 1 - s;
            pushq[s] = 0; popq[s] = 0; flq[s] = 0; ev[s] = 0; clr[s] = 0;
            ring[s][0] = 0; ring[s][1] = 0;
            nsie[s] = m_sie[s]; nrie[s] = m_rie[s]; nen[s] = m_en[s];
            nien[s] = m_ien[s]; nown[s] = m_own[s];
            if (v[s] && w[s]) begin
                case (ad[s])
                    2'd0: begin
                        if (be[s][1]) nown[s] = wd[s][15:8];
                        if (be[s][3]) begin
                            nien[s] = wd[s][31];
                            ring[s][1] = wd[s][29];
                            ring[s][0] = wd[s][30];
                        end
                    end
                    2'd1: begin
                        if (be[s][0]) begin nsie[s] = wd[s][2]; flq[s] = wd[s][3]; end
                        if (be[s][1]) begin
                            nrie[s] = wd[s][10]; nen[s] = wd[s][15]; clr[s] = wd[s][14];
                        end
                    end
                    2'd2: if (m_en[s]) begin
                        if (q[s].size() < DEPTH) pushq[s] = 1; else ev[s] = 1;
                    end
                    default: ;
                endcase
            end
            if (v[s] && !w[s] && ad[s] == 2'd3 && m_en[s]) begin
                if (q[r].size() > 0) popq[s] = 1; else ev[s] = 1;
            end
        end
        for (int t = 0; t < 2; t++)
            m_isync[t] = m_ien[t] && (ring[0][t] || ring[1][t]);
        for (int s = 0; s < 2; s++)
            if (popq[s]) m_last[s] = q[1 - s].pop_front();
        for (int s = 0; s < 2; s++) begin
            if (pushq[s]) q[s].push_back(wd[s]);
            if (flq[s]) q[s].delete();
            m_sie[s] = nsie[s]; m_rie[s] = nrie[s]; m_en[s] = nen[s];
            m_ien[s] = nien[s]; m_own[s] = nown[s];
            if (ev[s]) m_err[s] = 1; else if (clr[s]) m_err[s] = 0;
        end
    endtask

    function automatic string rd_tag(logic [1:0] a);
        return (a == 2'd0) ? "R1 sync read" : "R4 register read";
    endfunction

    task automatic cyc();
        #1;
        if (!rst) begin
            for (int s = 0; s < 2; s++) begin
                check(rd_tag(ad[s]), rdata[s], exp_rdata(s));
                check("R3 doorbell pulse", {31'b0, isync[s]}, {31'b0, m_isync[s]});
                check("R10 send irq", {31'b0, isend[s]}, {31'b0, m_sie[s] && q[s].size() == 0});
                check("R10 recv irq", {31'b0, irecv[s]}, {31'b0, m_rie[s] && q[1 - s].size() > 0});
            end
            if (want_on) begin
                if (want_kind == 0) check(want_tag, rdata[want_s], want_val);
                else check(want_tag, {31'b0, isync[want_s]}, want_val);
                want_on = 0;
            end
            model_step();
        end else begin
            model_reset();
        end
        @(negedge clk);
    endtask

    task automatic idle();
        for (int s = 0; s < 2; s++) begin
            v[s] = 0; w[s] = 0; ad[s] = 0; be[s] = 0; wd[s] = 0;
        end
    endtask

    task automatic op(int s, bit we, logic [1:0] a, logic [3:0] b, logic [31:0] d);
        v[s] = 1; w[s] = we; ad[s] = a; be[s] = b; wd[s] = d;
        cyc();
        idle();
    endtask

    task automatic rd_exp(int s, logic [1:0] a, logic [31:0] exp, string tag);
        want_on = 1; want_kind = 0; want_s = s; want_val = exp; want_tag = tag;
        op(s, 0, a, 4'hF, 0);
    endtask

    task automatic irq_exp(int s, logic exp, string tag);
        want_on = 1; want_kind = 1; want_s = s; want_val = {31'b0, exp}; want_tag = tag;
        cyc();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        model_reset();
        repeat (3) cyc();
        rst = 0;
        cyc();

        // R11 reset state
        rd_exp(0, 2'd1, 32'h0000_0101, "R11 ctrl A after reset");
        rd_exp(1, 2'd1, 32'h0000_0101, "R11 ctrl B after reset");
        rd_exp(0, 2'd3, 32'h0, "R11 recv A after reset");

        // R9 disabled send is ignored
        op(0, 1, 2'd2, 4'hF, 32'hDEAD_0001);
        rd_exp(1, 2'd1, 32'h0000_0101, "R9 ctrl B after disabled send");
        rd_exp(0, 2'd1, 32'h0000_0101, "R9 ctrl A no error");

        op(0, 1, 2'd1, 4'b0011, 32'h0000_8000);
        op(1, 1, 2'd1, 4'b0011, 32'h0000_8000);
        rd_exp(0, 2'd1, 32'h0000_8101, "R4 ctrl A enabled");

        // R4 ordering
        op(0, 1, 2'd2, 4'hF, 32'h1111_0001);
        op(0, 1, 2'd2, 4'hF, 32'h1111_0002);
        op(0, 1, 2'd2, 4'hF, 32'h1111_0003);
        rd_exp(1, 2'd1, 32'h0000_8001, "R4 ctrl B recv not empty");
        rd_exp(1, 2'd3, 32'h1111_0001, "R4 first word");
        rd_exp(1, 2'd3, 32'h1111_0002, "R4 second word");
        rd_exp(1, 2'd3, 32'h1111_0003, "R4 third word");

        // R6 empty read
        rd_exp(1, 2'd3, 32'h1111_0003, "R6 empty read returns last");
        rd_exp(1, 2'd1, 32'h0000_C101, "R6 error flag set");

        // R7 clear
        op(1, 1, 2'd1, 4'b0010, 32'h0000_C000);
        rd_exp(1, 2'd1, 32'h0000_8101, "R7 error cleared");

        // R5 full queue
        for (int i = 0; i < DEPTH; i++) op(0, 1, 2'd2, 4'hF, 32'h0000_0100 + i);
        rd_exp(0, 2'd1, 32'h0000_8102, "R5 send full");
        op(0, 1, 2'd2, 4'hF, 32'hBAD0_BAD0);
        rd_exp(0, 2'd1, 32'h0000_C102, "R5 overflow error");
        for (int i = 0; i < DEPTH; i++) rd_exp(1, 2'd3, 32'h0000_0100 + i, "R5 no overwrite");
        rd_exp(1, 2'd3, 32'h0000_0100 + DEPTH - 1, "R6 empty after drain");
        op(0, 1, 2'd1, 4'b0010, 32'h0000_C000);
        op(1, 1, 2'd1, 4'b0010, 32'h0000_C000);

        // R8 flush
        op(0, 1, 2'd2, 4'hF, 32'h2222_0001);
        op(0, 1, 2'd2, 4'hF, 32'h2222_0002);
        op(0, 1, 2'd1, 4'b0011, 32'h0000_8008);
        rd_exp(0, 2'd1, 32'h0000_8101, "R8 flushed, bit3 reads 0");
        rd_exp(1, 2'd1, 32'h0000_8101, "R8 peer sees empty");

        // R10 interrupts
        op(0, 1, 2'd1, 4'b0011, 32'h0000_8004);
        op(1, 1, 2'd1, 4'b0011, 32'h0000_8400);
        op(0, 1, 2'd2, 4'hF, 32'h3333_0001);
        rd_exp(1, 2'd3, 32'h3333_0001, "R10 recv word");

        // R9 disabled read
        op(1, 1, 2'd1, 4'b0011, 32'h0000_0000);
        op(0, 1, 2'd2, 4'hF, 32'h4444_0001);
        rd_exp(1, 2'd3, 32'h3333_0001, "R9 disabled read no pop");
        rd_exp(1, 2'd1, 32'h0000_0001, "R9 ctrl B no error");
        op(1, 1, 2'd1, 4'b0011, 32'h0000_8000);
        rd_exp(1, 2'd3, 32'h4444_0001, "R9 word kept");

        // R1 and R2 sync byte
        op(0, 1, 2'd0, 4'b0010, 32'h0000_5A00);
        rd_exp(1, 2'd0, 32'h0000_005A, "R1 peer byte");
        rd_exp(0, 2'd0, 32'h0000_5A00, "R1 own byte");
        op(0, 1, 2'd0, 4'b0001, 32'h0000_FF00);
        rd_exp(1, 2'd0, 32'h0000_005A, "R2 lane off");
        op(0, 1, 2'd0, 4'hF, 32'h8000_3C00);
        rd_exp(0, 2'd0, 32'h8000_3C00, "R2 full write");

        // R3 doorbells
        op(1, 1, 2'd0, 4'b1000, 32'h4000_0000);
        irq_exp(0, 1'b1, "R3 ring A pulse");
        irq_exp(0, 1'b0, "R3 pulse one cycle");
        op(1, 1, 2'd0, 4'b1000, 32'h2000_0000);
        irq_exp(1, 1'b0, "R3 no pulse when disabled");
        op(1, 1, 2'd0, 4'b1000, 32'h8000_0000);
        op(0, 1, 2'd0, 4'b1000, 32'h2000_0000);
        irq_exp(1, 1'b1, "R3 ring B from A");
        op(1, 1, 2'd0, 4'b0111, 32'h2000_0000);
        irq_exp(1, 1'b0, "R3 lane 3 off");

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            for (int s = 0; s < 2; s++) begin
                if ($urandom_range(0, 2) == 0) begin
                    v[s] = 0; w[s] = 0;
                end else begin
                    v[s]  = 1;
                    w[s]  = $urandom_range(0, 1) == 1;
                    ad[s] = 2'($urandom_range(0, 3));
                    be[s] = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
                    wd[s] = $urandom;
                    if (ad[s] == 2'd1) begin
                        wd[s][15] = $urandom_range(0, 9) != 0;
                        wd[s][3]  = $urandom_range(0, 15) == 0;
                    end
                end
            end
            cyc();
        end
        idle();
        cyc();
        finish_run();
    end

endmodule